// File: doc/BRIEF.md
# Three-Wire DAC Write Sequencer

This block sits on the host side of an octal 8-bit serial DAC and produces its chip-select, serial clock and serial data lines. A single write arrives on a valid/ready handshake as a 3-bit channel index and an 8-bit code. The block sends it as one 16-bit frame: five zero pad bits, then the channel, then the code, most significant bit first. The DAC keeps only the last eleven bits it receives.

A local eight-entry code store is loaded through a plain write port. A refresh command replays all eight stored codes as eight back-to-back frames for channels 0 to 7. Each timing minimum of the serial link is a parameter in system-clock cycles: clock high, clock low, chip-select setup, chip-select hold and chip-select high time. Data changes only on falling clock edges, so each bit stays stable for a full low phase before the rising sampling edge and a full high phase after it.

Top module: `dac3w_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is high and `req_ready_o` is high. Every code-store entry holds mid-scale 0x80.
- R2: A frame contains exactly 16 rising clock edges while chip select is low. The bits sampled on those edges, MSB first, are 5'b00000, then the channel (3 bits), then the code (8 bits).
- R3: The serial clock idles high and is high in the cycle where chip select falls and in the cycle where it rises.
- R4: Each clock low phase lasts at least `LO_CYC` cycles and each high phase inside a frame lasts at least `HI_CYC` cycles.
- R5: While chip select stays low, serial data changes only in the cycle where the clock falls.
- R6: Chip select is low at least `CSS_CYC` cycles before the first rising edge. The last rising edge comes at least `CSH_CYC` cycles before chip select rises.
- R7: Chip select stays high at least `CSW_CYC` cycles between frames.
- R8: `req_ready_o` drops in the cycle after a request is accepted and stays low until the inter-frame high time ends. With the default timing this is 68 cycles for one frame.
- R9: A refresh sends eight frames for channels 0, 1, …, 7 in that order. Each frame carries the stored code of its channel. No single write is accepted until the eighth frame has finished.
- R10: If `refresh_i` and `req_valid_i` are both high in the same accepting cycle, the refresh is taken and the write waits.
- R11: A code-store write replaces the entry for later frames. A frame carries the value the entry held when that frame was launched, so a write that lands after launch does not alter a frame already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Single-write request valid |
| req_ready_o | output | 1 | Sequencer can accept a write or refresh |
| req_ch_i | input | 3 | Channel index of the single write |
| req_code_i | input | 8 | Code of the single write |
| refresh_i | input | 1 | Refresh-all request, taken when ready |
| rf_we_i | input | 1 | Code-store write enable |
| rf_addr_i | input | 3 | Code-store entry |
| rf_data_i | input | 8 | Code-store write data |
| dac_cs_n_o | output | 1 | Chip select to the DAC, active low |
| dac_sclk_o | output | 1 | Serial clock to the DAC, idles high |
| dac_sdi_o | output | 1 | Serial data to the DAC |

## Verification
The assertions assume the requester treats `refresh_i` like a valid that may be dropped once the request is taken. They also assume that any request seen while `req_ready_o` is high is accepted in that cycle; the rule that ready falls in the next cycle depends on this. The stimulus changes inputs only on falling system-clock edges. It releases `refresh_i` in the cycle after acceptance and holds `req_valid_i` until its request is taken. Code-store writes are placed inside a refresh at known points, so the expected value of each frame is fixed.

// File: rtl/dac3w_pkg.sv
package dac3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } frm_state_e;
endpackage

// File: rtl/dac3w_codes.sv
module dac3w_codes #(
  parameter int ADDR_W = 3,
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [CODE_W-1:0] rdata_o
);
  localparam int CH_N = 1 << ADDR_W;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] mem [CH_N];

  for (genvar g = 0; g < CH_N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem[g] <= MID;
      else if (we_i && waddr_i == ADDR_W'(g))   mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/dac3w_frame.sv
module dac3w_frame
  import dac3w_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CSS_CYC = 2,
  parameter int LO_CYC  = 2,
  parameter int HI_CYC  = 2,
  parameter int CSH_CYC = 2,
  parameter int CSW_CYC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               idle_o,
  output logic               cs_n_o,
  output logic               sclk_o,
  output logic               sdi_o
);
  localparam int TAIL_CYC = (HI_CYC > CSH_CYC) ? HI_CYC : CSH_CYC;
  localparam int M1 = (CSS_CYC > LO_CYC) ? CSS_CYC : LO_CYC;
  localparam int M2 = (TAIL_CYC > CSW_CYC) ? TAIL_CYC : CSW_CYC;
  localparam int MAX_CYC = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  frm_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bitn;
  logic [FRAME_W-1:0] shreg;

  assign idle_o = (state == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      cs_n_o <= 1'b1;
      sclk_o <= 1'b1;
      sdi_o  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          shreg  <= frame_i;
          sdi_o  <= frame_i[FRAME_W-1];
          cs_n_o <= 1'b0;
          cnt    <= CNT_W'(CSS_CYC - 1);
          bitn   <= '0;
          state  <= ST_LEAD;
        end
        ST_LEAD: if (cnt == '0) begin
          sclk_o <= 1'b0;
          cnt    <= CNT_W'(LO_CYC - 1);
          state  <= ST_LOW;
        end else cnt <= cnt - 1'b1;
        ST_LOW: if (cnt == '0) begin
          sclk_o <= 1'b1;
          cnt    <= (bitn == LAST_BIT) ? CNT_W'(TAIL_CYC - 1) : CNT_W'(HI_CYC - 1);
          state  <= ST_HIGH;
        end else cnt <= cnt - 1'b1;
        ST_HIGH: if (cnt == '0) begin
          if (bitn == LAST_BIT) begin
            cs_n_o <= 1'b1;
            cnt    <= CNT_W'(CSW_CYC - 1);
            state  <= ST_GAP;
          end else begin
            // next bit launched on the falling edge
            sclk_o <= 1'b0;
            shreg  <= shreg << 1;
            sdi_o  <= shreg[FRAME_W-2];
            bitn   <= bitn + 1'b1;
            cnt    <= CNT_W'(LO_CYC - 1);
            state  <= ST_LOW;
          end
        end else cnt <= cnt - 1'b1;
        ST_GAP: if (cnt == '0) state <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac3w_seq.sv
module dac3w_seq #(
  parameter int ADDR_W  = 3,
  parameter int CODE_W  = 8,
  parameter int FRAME_W = 16,
  parameter int CSS_CYC = 2,
  parameter int LO_CYC  = 2,
  parameter int HI_CYC  = 2,
  parameter int CSH_CYC = 2,
  parameter int CSW_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_ch_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              refresh_i,
  input  logic              rf_we_i,
  input  logic [ADDR_W-1:0] rf_addr_i,
  input  logic [CODE_W-1:0] rf_data_i,
  output logic              dac_cs_n_o,
  output logic              dac_sclk_o,
  output logic              dac_sdi_o
);
  localparam int PAD_W = FRAME_W - ADDR_W - CODE_W;
  localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'((1 << ADDR_W) - 1);

  logic              eng_idle, ref_active, start;
  logic              acc_wr, acc_rf, ref_go;
  logic [ADDR_W-1:0] ref_idx, rd_idx, sel_ch;
  logic [CODE_W-1:0] rf_rdata, sel_code;
  logic [FRAME_W-1:0] frame;

  assign req_ready_o = eng_idle & ~ref_active;
  assign acc_rf = req_ready_o & refresh_i;
  assign acc_wr = req_ready_o & req_valid_i & ~refresh_i;
  assign ref_go = ref_active & eng_idle;
  assign start  = acc_wr | acc_rf | ref_go;

  assign rd_idx   = ref_go ? ref_idx : '0;
  assign sel_ch   = acc_wr ? req_ch_i : rd_idx;
  assign sel_code = acc_wr ? req_code_i : rf_rdata;
  assign frame    = {{PAD_W{1'b0}}, sel_ch, sel_code};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_active <= 1'b0;
      ref_idx    <= '0;
    end else if (acc_rf) begin
      ref_active <= 1'b1;
      ref_idx    <= ADDR_W'(1);
    end else if (ref_go) begin
      ref_idx <= ref_idx + 1'b1;
      if (ref_idx == LAST_CH) ref_active <= 1'b0;
    end
  end

  dac3w_codes #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_codes (
    .clk_i, .rst_ni,
    .we_i(rf_we_i), .waddr_i(rf_addr_i), .wdata_i(rf_data_i),
    .raddr_i(rd_idx), .rdata_o(rf_rdata)
  );

  dac3w_frame #(
    .FRAME_W(FRAME_W), .CSS_CYC(CSS_CYC), .LO_CYC(LO_CYC),
    .HI_CYC(HI_CYC), .CSH_CYC(CSH_CYC), .CSW_CYC(CSW_CYC)
  ) u_frame (
    .clk_i, .rst_ni,
    .start_i(start), .frame_i(frame), .idle_o(eng_idle),
    .cs_n_o(dac_cs_n_o), .sclk_o(dac_sclk_o), .sdi_o(dac_sdi_o)
  );
endmodule

// File: rtl/dac3w_seq_chk.sv
module dac3w_seq_chk #(
  parameter int FRAME_W = 16,
  parameter int CSS_CYC = 2,
  parameter int LO_CYC  = 2,
  parameter int HI_CYC  = 2,
  parameter int CSH_CYC = 2,
  parameter int CSW_CYC = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_n_i,
  input logic sclk_i,
  input logic sdi_i,
  input logic req_valid_i,
  input logic refresh_i,
  input logic req_ready_i
);
  logic       sclk_q, cs_q, sdi_q, seen_rise;
  logic [7:0] sclk_run, cs_lo_run, cs_hi_run, rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b1;
      cs_q      <= 1'b1;
      sdi_q     <= 1'b0;
      seen_rise <= 1'b0;
      sclk_run  <= 8'hff;
      cs_lo_run <= '0;
      cs_hi_run <= 8'hff;
      rise_cnt  <= '0;
    end else begin
      sclk_q    <= sclk_i;
      cs_q      <= cs_n_i;
      sdi_q     <= sdi_i;
      sclk_run  <= (sclk_i != sclk_q) ? 8'd1 : ((sclk_run == 8'hff) ? sclk_run : sclk_run + 8'd1);
      cs_lo_run <= cs_n_i ? 8'd0 : ((cs_lo_run == 8'hff) ? cs_lo_run : cs_lo_run + 8'd1);
      cs_hi_run <= !cs_n_i ? 8'd0 : ((cs_hi_run == 8'hff) ? cs_hi_run : cs_hi_run + 8'd1);
      if (cs_n_i) begin
        rise_cnt  <= '0;
        seen_rise <= 1'b0;
      end else if (sclk_i && !sclk_q) begin
        rise_cnt  <= rise_cnt + 8'd1;
        seen_rise <= 1'b1;
      end
    end
  end

  // R2
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i && !cs_q) |-> rise_cnt == 8'(FRAME_W));
  // R3
  sclk_at_cs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i != cs_q) |-> sclk_i);
  // R3
  sclk_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i && cs_q) |-> sclk_i);
  // R4
  low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && sclk_i && !sclk_q) |-> sclk_run >= 8'(LO_CYC));
  // R4
  high_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && !sclk_i && sclk_q && seen_rise) |-> sclk_run >= 8'(HI_CYC));
  // R5
  sdi_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && !cs_q && sdi_i != sdi_q) |-> (!sclk_i && sclk_q));
  // R6
  cs_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && sclk_i && !sclk_q && !seen_rise) |-> cs_lo_run >= 8'(CSS_CYC));
  // R6
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i && !cs_q) |-> sclk_run >= 8'(CSH_CYC));
  // R7
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && cs_q) |-> cs_hi_run >= 8'(CSW_CYC));
  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_i && (req_valid_i || refresh_i)) |=> !req_ready_i);
  // R8
  busy_while_cs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_i |-> !req_ready_i);
endmodule

bind dac3w_seq dac3w_seq_chk #(
  .FRAME_W(FRAME_W), .CSS_CYC(CSS_CYC), .LO_CYC(LO_CYC),
  .HI_CYC(HI_CYC), .CSH_CYC(CSH_CYC), .CSW_CYC(CSW_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cs_n_i(dac_cs_n_o), .sclk_i(dac_sclk_o), .sdi_i(dac_sdi_o),
  .req_valid_i(req_valid_i), .refresh_i(refresh_i), .req_ready_i(req_ready_o)
);

// File: tb/dac3w_seq_bench.sv
module dac3w_seq_bench;
  localparam int CSS = 2, LO = 2, HI = 2, CSH = 2, CSW = 2;
  localparam int TAIL = (HI > CSH) ? HI : CSH;
  localparam int BUSY_CYC = CSS + 16 * LO + 15 * HI + TAIL + CSW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, refresh = 1'b0, rf_we = 1'b0;
  logic [2:0] req_ch = '0, rf_addr = '0;
  logic [7:0] req_code = '0, rf_data = '0;
  logic req_ready, cs_n, sclk, sdi;

  always #4 clk = ~clk;

  dac3w_seq u_dac3w_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_ch_i(req_ch), .req_code_i(req_code), .refresh_i(refresh),
    .rf_we_i(rf_we), .rf_addr_i(rf_addr), .rf_data_i(rf_data),
    .dac_cs_n_o(cs_n), .dac_sclk_o(sclk), .dac_sdi_o(sdi)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_rf [8];

  // serial bus monitor
  logic [15:0] cap [64];
  int ncap = 0, nrise = 0;
  logic [15:0] sh = '0;
  logic pcs = 1'b1, psclk = 1'b1, psdi = 1'b0;
  int sclk_len = 1000, cs_lo_len = 0, cs_hi_len = 1000;
  int min_lo = 1000, min_hi = 1000, min_css = 1000, min_csh = 1000, min_csw = 1000;
  int r2_bad = 0, r3_bad = 0, r5_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n != pcs) begin
        if (!sclk) r3_bad++;
        if (!cs_n) begin
          if (cs_hi_len < min_csw) min_csw = cs_hi_len;
          nrise = 0;
          sh = '0;
        end else begin
          if (sclk_len < min_csh) min_csh = sclk_len;
          if (nrise != 16) r2_bad++;
          if (ncap < 64) cap[ncap] = sh;
          ncap++;
        end
      end else if (cs_n && !sclk) r3_bad++;
      if (!cs_n && sclk != psclk) begin
        if (sclk) begin
          if (sclk_len < min_lo) min_lo = sclk_len;
          if (nrise == 0 && cs_lo_len < min_css) min_css = cs_lo_len;
          sh = {sh[14:0], sdi};
          nrise++;
        end else if (nrise > 0 && sclk_len < min_hi) min_hi = sclk_len;
      end
      if (!cs_n && !pcs && sdi != psdi && !(psclk && !sclk)) r5_bad++;
      sclk_len  = (sclk != psclk) ? 1 : sclk_len + 1;
      cs_lo_len = cs_n ? 0 : cs_lo_len + 1;
      cs_hi_len = !cs_n ? 0 : cs_hi_len + 1;
      pcs = cs_n; psclk = sclk; psdi = sdi;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    for (int t = 0; t < 20000 && ncap < n; t++) @(negedge clk);
  endtask

  task automatic rf_write(input logic [2:0] a, input logic [7:0] d);
    rf_we = 1'b1; rf_addr = a; rf_data = d;
    @(negedge clk);
    rf_we = 1'b0;
    exp_rf[a] = d;
  endtask

  task automatic t_reset;
    check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    check(sclk == 1'b1, "R1 sclk", sclk, 1);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
  endtask

  task automatic t_single(input logic [2:0] ch, input logic [7:0] code);
    int base, n;
    base = ncap;
    req_valid = 1'b1; req_ch = ch; req_code = code;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!req_ready && n < 1000) begin n++; @(negedge clk); end
    check(n == BUSY_CYC, "R8 busy cycles", n, BUSY_CYC);
    wait_frames(base + 1);
    check(cap[base] == {5'b0, ch, code}, "R2 frame", int'(cap[base]), int'({5'b0, ch, code}));
  endtask

  // R9 R10 R11: refresh with a pending write and code-store writes during the burst
  task automatic t_refresh(input bit with_wr, input bit mid_wr);
    int base, ready_hi;
    logic [7:0] snap [8];
    base = ncap;
    refresh = 1'b1;
    if (with_wr) begin req_valid = 1'b1; req_ch = 3'd6; req_code = 8'h5A; end
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    refresh = 1'b0;
    for (int i = 0; i < 8; i++) snap[i] = exp_rf[i];
    if (mid_wr) begin
      rf_write(3'd0, 8'h11);   // frame 0 already launched: old value stays
      rf_write(3'd7, 8'hC3);   // frame 7 not yet launched: new value used
      snap[7] = 8'hC3;
    end
    ready_hi = 0;
    while (ncap < base + 8 && ready_hi < 100000) begin
      if (req_ready) ready_hi++;
      @(negedge clk);
      if (ready_hi == 0 && ncap < base + 8) ready_hi = 0;
    end
    check(ready_hi == 0, "R9 no accept during refresh", ready_hi, 0);
    for (int i = 0; i < 8; i++)
      check(cap[base + i] == {5'b0, 3'(i), snap[i]}, "R9 R11 refresh frame",
            int'(cap[base + i]), int'({5'b0, 3'(i), snap[i]}));
    if (with_wr) begin
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wait_frames(base + 9);
      check(cap[base + 8] == {5'b0, 3'd6, 8'h5A}, "R10 write after refresh",
            int'(cap[base + 8]), int'({5'b0, 3'd6, 8'h5A}));
    end
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_timing;
    check(r2_bad == 0, "R2 rise count", r2_bad, 0);
    check(r3_bad == 0, "R3 sclk at cs edges", r3_bad, 0);
    check(min_lo >= LO, "R4 low phase", min_lo, LO);
    check(min_hi >= HI, "R4 high phase", min_hi, HI);
    check(r5_bad == 0, "R5 sdi change", r5_bad, 0);
    check(min_css >= CSS, "R6 cs setup", min_css, CSS);
    check(min_csh >= CSH, "R6 cs hold", min_csh, CSH);
    check(min_csw >= CSW, "R7 cs gap", min_csw, CSW);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_rf[i] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_refresh(1'b0, 1'b0);          // R1 mid-scale contents
    t_single(3'd0, 8'h00);
    t_single(3'd7, 8'hFF);
    t_single(3'd5, 8'hA5);
    t_single(3'd2, 8'h3C);
    for (int i = 0; i < 8; i++) rf_write(3'(i), 8'(i * 37 + 11));
    t_refresh(1'b1, 1'b1);
    t_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule